// File: doc/BRIEF.md
# Edge-Triggered Counter Capture Unit

This unit watches one asynchronous input pin and timestamps its transitions. On the chosen transition direction it copies the value of an external free-running counter into a holding register and raises a sticky event flag. An interrupt request follows that flag, gated by an enable input. The counter, its clocking and any register access are provided elsewhere.

The pin is first brought into the clock domain by a two-flop synchroniser. It can then pass through an optional glitch filter. The filter accepts a new level only after that level has been seen on four consecutive clock cycles. Each path has its own edge detector, so switching between the filtered and unfiltered paths does not produce a spurious capture. Changing the edge-direction input while the pin is steady does not produce one either.

Top module: `icap_unit`

## Requirements
- R1: With the filter off, a pin change driven before clock edge 1 updates the capture register and flag on rising edge 3. The value stored is the counter value present just before that edge.
- R2: With the filter on, the level seen by the edge detector changes only after four consecutive synchronised samples agree on the new level. A pin pulse that lasts 1 to 3 cycles causes no capture, and a 4-cycle pulse causes one.
- R3: Enabling the filter delays a capture by exactly four more cycles, to rising edge 7 after the pin change. The stored value is the counter value present just before edge 7.
- R4: When edge_rise_i is 0, only a high-to-low pin transition triggers. When it is 1, only a low-to-high transition triggers. The opposite transition leaves the flag and the capture register unchanged.
- R5: On a trigger, cap_o takes the counter value and flag_o is set in the same cycle. Without a trigger, cap_o holds its value.
- R6: flag_o stays set until flag_clr_i is high at a clock edge. A clear with no trigger in the same cycle makes flag_o 0 in the next cycle.
- R7: If flag_clr_i and a trigger occur in the same cycle, flag_o is 1 afterwards and cap_o holds the new value.
- R8: irq_o is 1 exactly when flag_o is 1 and irq_en_i is 1.
- R9: Toggling edge_rise_i while the pin is steady causes no capture.
- R10: While rst_ni is low, and right after it is released, cap_o is 0, flag_o is 0 and irq_o is 0. The pin is taken to be low at reset.
- R11: Toggling filt_en_i while the pin is steady and settled causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous capture pin |
| cnt_i | input | 16 | Free-running counter value |
| filt_en_i | input | 1 | 1 selects the filtered path |
| edge_rise_i | input | 1 | 0 = falling edge, 1 = rising edge |
| flag_clr_i | input | 1 | Write-one clear strobe for the flag |
| irq_en_i | input | 1 | Interrupt enable |
| cap_o | output | 16 | Captured counter value |
| flag_o | output | 1 | Capture event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives the pin and the counter half a period away from the active edge, so each pin change can be tied to a known counter value. On the unfiltered path, the flag must still be clear after rising edge 2 and set after edge 3. On the filtered path, it must still be clear after edge 6 and set after edge 7. The captured value is checked against the counter value from the cycle before the due edge. The flag clear takes effect one edge after its strobe, and the interrupt output is sampled combinationally within the same cycle.

// File: rtl/icap_pkg.sv
package icap_pkg;
  parameter int unsigned CNT_W_DEF    = 16;
  parameter int unsigned SYNC_DEF     = 2;
  parameter int unsigned FILT_LEN_DEF = 4;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic lvl_o
);
  localparam int unsigned RUN_W = $clog2(LEN + 1);

  logic [LEN-1:0] hist_q;
  logic           held_q;
  logic           all_hi, all_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      held_q <= 1'b0;
    end else begin
      hist_q <= {hist_q[LEN-2:0], lvl_i};
      held_q <= lvl_o;
    end
  end

  assign all_hi = &hist_q;
  assign all_lo = ~|hist_q;

  always_comb begin
    lvl_o = held_q;
    if (all_hi)      lvl_o = 1'b1;
    else if (all_lo) lvl_o = 1'b0;
  end

  // independent run-length tracker for the agreement check
  logic [RUN_W-1:0] run_q;
  logic             last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= RUN_W'(LEN);
      last_q <= 1'b0;
    end else begin
      last_q <= lvl_i;
      if (lvl_i != last_q)          run_q <= RUN_W'(1);
      else if (run_q < RUN_W'(LEN)) run_q <= run_q + RUN_W'(1);
    end
  end

  p_filter_agree_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_o != held_q) |-> (run_q >= RUN_W'(LEN) && last_q == lvl_o));
endmodule

// File: rtl/icap_edge.sv
module icap_edge
  import icap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  edge_sel_e sel_i,
  output logic      trig_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  // trigger depends on level history only, never on sel changes
  assign trig_o = (sel_i == EDGE_RISE) ? (lvl_i & ~prev_q) : (~lvl_i & prev_q);

  p_edge_needs_change_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (lvl_i != prev_q));
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int unsigned CNT_W    = CNT_W_DEF,
  parameter int unsigned SYNC_N   = SYNC_DEF,
  parameter int unsigned FILT_LEN = FILT_LEN_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             filt_en_i,
  input  logic             edge_rise_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic      pin_s, pin_f;
  logic      trig_raw, trig_flt, trig;
  edge_sel_e sel;

  assign sel = edge_sel_e'(edge_rise_i);

  icap_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  icap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(pin_s), .lvl_o(pin_f)
  );

  // separate detectors so a path switch never fabricates an edge
  icap_edge u_edge_raw (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(pin_s), .sel_i(sel), .trig_o(trig_raw)
  );

  icap_edge u_edge_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(pin_f), .sel_i(sel), .trig_o(trig_flt)
  );

  assign trig = filt_en_i ? trig_flt : trig_raw;

  logic [CNT_W-1:0] cap_q;
  logic             flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (trig) cap_q <= cnt_i;
      flag_q <= trig | (flag_q & ~flag_clr_i);
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

  p_capture_value_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> (cap_o == $past(cnt_i)) && flag_o);
  p_cap_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig |=> $stable(cap_o));
  p_flag_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i && !trig) |=> flag_o);
  p_flag_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !trig) |=> !flag_o);
  p_clear_collide_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && trig) |=> flag_o);
  p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && irq_en_i));
endmodule

// File: tb/tb_icap_unit.sv
`timescale 1ns/1ps
module tb_icap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [15:0] cnt = 16'h1000;
  logic        filt_en = 1'b0, rise = 1'b0, clr = 1'b0, irq_en = 1'b0;
  logic [15:0] cap;
  logic        flag, irq;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 16'd1;

  icap_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .cnt_i(cnt),
    .filt_en_i(filt_en), .edge_rise_i(rise), .flag_clr_i(clr), .irq_en_i(irq_en),
    .cap_o(cap), .flag_o(flag), .irq_o(irq)
  );

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    clr = 1'b1; step(1); clr = 1'b0;
  endtask

  task automatic trial(bit f, bit s, bit from);
    logic [15:0] c;
    int lat;
    bit exp;
    filt_en = f; rise = s; pin = from;
    step(12);
    clear_flag();
    step(1);
    chk("R6 flag cleared", flag, 0);
    pin = ~from; c = cnt;
    lat = f ? 7 : 3;
    step(lat - 1);
    chk(f ? "R3 not early" : "R1 not early", flag, 0);
    step(1);
    exp = s ? (!from) : from;
    chk("R4 edge select", flag, exp);
    if (exp) chk(f ? "R3 capture value" : "R1 capture value", cap, c + 16'(lat - 1));
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] c;
    step(3);
    chk("R10 cap in reset", cap, 0);
    chk("R10 flag in reset", flag, 0);
    chk("R10 irq in reset", irq, 0);
    rst_n = 1'b1;
    step(2);
    chk("R10 cap after reset", cap, 0);
    chk("R10 flag after reset", flag, 0);

    // sweep: filter x edge select x transition direction
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 2; s++)
        for (int fr = 0; fr < 2; fr++)
          trial(f[0], s[0], fr[0]);

    // R2: short pulses rejected by filter, 4-cycle accepted
    filt_en = 1'b1; rise = 1'b1; pin = 1'b0;
    step(12); clear_flag();
    for (int w = 1; w <= 4; w++) begin
      pin = 1'b1; step(w); pin = 1'b0;
      step(14);
      chk("R2 pulse width", flag, (w >= 4) ? 1 : 0);
      clear_flag();
    end
    // R1: unfiltered path passes a 1-cycle pulse
    filt_en = 1'b0; step(2);
    pin = 1'b1; step(1); pin = 1'b0; step(6);
    chk("R1 short pulse unfiltered", flag, 1);
    clear_flag();

    // R7 / R6 / R8
    filt_en = 1'b0; rise = 1'b1; pin = 1'b0; step(10);
    pin = 1'b1; step(4);
    chk("R5 flag set", flag, 1);
    pin = 1'b0; step(6);
    chk("R4 opposite edge keeps flag", flag, 1);
    c = cnt; pin = 1'b1;
    step(2); clr = 1'b1; step(1); clr = 1'b0;
    chk("R7 clear collides with capture", flag, 1);
    chk("R7 new value", cap, c + 16'd2);
    irq_en = 1'b0; #1;
    chk("R8 irq masked", irq, 0);
    irq_en = 1'b1; #1;
    chk("R8 irq raised", irq, 1);
    clear_flag();
    chk("R6 clear alone", flag, 0);
    chk("R8 irq drops", irq, 0);

    // R9: edge select toggling on steady pin
    for (int lv = 0; lv < 2; lv++) begin
      pin = lv[0]; step(12); clear_flag();
      for (int k = 0; k < 6; k++) begin rise = ~rise; step(1); end
      step(8);
      chk("R9 select toggle no capture", flag, 0);
    end

    // R11: filter enable toggling on steady pin
    for (int lv = 0; lv < 2; lv++) begin
      pin = lv[0]; step(12); clear_flag();
      for (int k = 0; k < 6; k++) begin filt_en = ~filt_en; rise = k[0]; step(1); end
      step(8);
      chk("R11 filter toggle no capture", flag, 0);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule